// File: doc/BRIEF.md
# Lane Marker Monitor

This block watches one physical lane of a multi-lane 64b/66b receive path after block lock has been reached. Each valid 66-bit block is classified as either an alignment marker or ordinary traffic. The block finds out which logical lane is carried on the physical lane by matching marker identifiers against a programmed table. It then tracks the marker cadence and reports per-lane health to the deskew and fault logic downstream.

Once a marker has been accepted, the monitor expects the next marker after a programmed number of valid blocks. At that slot it raises a one-cycle pulse if the expected marker is absent, malformed or carries the wrong identifier. A marker that turns up off-cadence raises a held length error. Four marker errors in a row raise a held repeat flag and drop synchronisation. At every on-time marker, a bit-interleaved parity byte collected over the preceding interval is compared with the byte the marker carries.

The marker table and the interval are static and may only change while reset is asserted.

Top module: `lane_marker_monitor`

## Requirements
- R1: While reset is asserted, and on the first sample after it, every output is zero.
- R2: While `blk_lock` is low, `lane_synced`, `lane_demuxed`, `len_err` and `rep_err` are zero on the next sample, and all cadence state is discarded.
- R3: A marker block has sync header 2'b10, its identifier in bytes 0..2 (byte 0 = `blk_data[7:0]`), its parity byte in byte 3, bytes 4..6 equal to the bitwise inverse of bytes 0..2, and byte 7 equal to the inverse of byte 3. Its identifier must equal table entry k, which is held at `mk_table[24k +: 24]`. While unsynced, the first such marker sets `lane_synced` and `lane_demuxed` and sets `lane_num` to k. A block that is well formed but whose identifier is in no entry leaves the lane unsynced.
- R4: After an accepted marker, the next marker is due after exactly `mk_gap_m1`+1 valid non-marker blocks. Cycles with `blk_vld` low are not counted.
- R5: `mf_err` pulses for one cycle when, at a due slot, the block is not a valid marker carrying the locked lane's identifier. This covers a missing marker, a malformed marker and a marker with the wrong identifier. The cadence restarts from that slot.
- R6: A valid marker arriving before its due slot sets `len_err` and restarts the interval from that marker. `len_err` stays high until a correct marker arrives at a due slot.
- R7: Each due-slot error and each early marker counts as one consecutive marker error, and a correct on-time marker resets the count. On the fourth consecutive error, `rep_err` is set and `lane_synced` and `lane_demuxed` drop. `rep_err` clears when a marker is next accepted.
- R8: Parity bit i is the XOR of payload bits i, i+8, ..., i+56 of every valid block, with sync bit 0 also folded into bit 3 and sync bit 1 into bit 4. The parity collection restarts at each accepted marker and at each due slot, and includes that block. At a correct on-time marker, `bip_err` pulses for one cycle with the collected parity XOR the marker's byte 3. Otherwise it is zero.
- R9: While the lane stays synced, `lane_num` does not change, even when a marker with another identifier arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_lock | input | 1 | Upstream block lock level |
| blk_vld | input | 1 | Block valid strobe |
| blk_hdr | input | 2 | Sync header of the block |
| blk_data | input | 64 | Block payload |
| mk_gap_m1 | input | 16 | Valid blocks between markers, minus one |
| mk_table | input | LANES*24 | Marker identifier per logical lane |
| lane_synced | output | 1 | Lane synchronised to markers |
| lane_demuxed | output | 1 | Logical lane identified |
| lane_num | output | IDX_W | Logical lane on this physical lane |
| len_err | output | 1 | Held off-cadence marker error |
| rep_err | output | 1 | Held four-consecutive-error flag |
| mf_err | output | 1 | Pulsed bad marker at due slot |
| bip_err | output | 8 | Pulsed parity mismatch bits |

## Verification
Every output is registered once, so a result is due on the first rising edge after the block that causes it has been presented. Reset release passes through two synchroniser stages before the monitor leaves reset. The bench drives each block just after a falling edge and holds it for exactly one rising edge. It then reads the outputs 1 ns after that edge, where the reaction to that block, and to nothing later, is visible. Pulsed results are also checked as zero on the block that follows them.

// File: rtl/lmm_pkg.sv
package lmm_pkg;

  localparam logic [1:0] HDR_CTRL = 2'b10;
  localparam int unsigned ID_W = 24;

  // Interleaved parity of one 66-bit block.
  function automatic logic [7:0] blk_parity(input logic [1:0] hdr, input logic [63:0] d);
    logic [7:0] p;
    p = '0;
    for (int k = 0; k < 8; k++) p = p ^ d[8*k +: 8];
    p[3] = p[3] ^ hdr[0];
    p[4] = p[4] ^ hdr[1];
    return p;
  endfunction

  // Marker shape: control header, upper half the inverse of the lower half.
  function automatic logic marker_shape(input logic [1:0] hdr, input logic [63:0] d);
    return (hdr == HDR_CTRL) && (d[63:32] == ~d[31:0]);
  endfunction

endpackage

// File: rtl/lmm_match.sv
module lmm_match
  import lmm_pkg::*;
#(
  parameter int unsigned LANES = 4,
  parameter int unsigned IDX_W = 2
) (
  input  logic [1:0]          hdr_i,
  input  logic [63:0]         data_i,
  input  logic [LANES*ID_W-1:0] table_i,
  output logic                is_mk_o,
  output logic [IDX_W-1:0]    hit_idx_o
);

  logic [LANES-1:0] eq;
  logic             shape_ok;

  assign shape_ok = marker_shape(hdr_i, data_i);

  for (genvar k = 0; k < LANES; k++) begin : g_entry
    assign eq[k] = (data_i[ID_W-1:0] == table_i[k*ID_W +: ID_W]);
  end

  always_comb begin
    hit_idx_o = '0;
    for (int k = LANES - 1; k >= 0; k--) begin
      if (eq[k]) hit_idx_o = IDX_W'(k);
    end
  end

  assign is_mk_o = shape_ok && (|eq);

endmodule

// File: rtl/lmm_bip.sv
module lmm_bip
  import lmm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en_i,
  input  logic        restart_i,
  input  logic [1:0]  hdr_i,
  input  logic [63:0] data_i,
  output logic [7:0]  acc_o
);

  logic [7:0] acc_q, acc_d, blk_p;

  assign blk_p = blk_parity(hdr_i, data_i);

  always_comb begin
    acc_d = acc_q;
    if (en_i) acc_d = restart_i ? blk_p : (acc_q ^ blk_p);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign acc_o = acc_q;

endmodule

// File: rtl/lmm_track.sv
module lmm_track #(
  parameter int unsigned IDX_W = 2,
  parameter int unsigned GAP_W = 16,
  parameter int unsigned ERR_RUN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lock_i,
  input  logic             vld_i,
  input  logic             is_mk_i,
  input  logic [IDX_W-1:0] hit_idx_i,
  input  logic [7:0]       mk_bip_i,
  input  logic [7:0]       acc_i,
  input  logic [GAP_W-1:0] gap_m1_i,
  output logic             restart_o,
  output logic             synced_o,
  output logic             demux_o,
  output logic [IDX_W-1:0] lane_o,
  output logic             len_o,
  output logic             rep_o,
  output logic             mf_o,
  output logic [7:0]       bip_o
);

  localparam int unsigned CNT_W = GAP_W + 1;
  localparam int unsigned RUN_W = $clog2(ERR_RUN + 1);

  logic             synced_q, synced_d, demux_q, demux_d;
  logic [IDX_W-1:0] lane_q, lane_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, due_lim;
  logic [RUN_W-1:0] run_q, run_d;
  logic             len_q, len_d, rep_q, rep_d, mf_q, mf_d;
  logic [7:0]       bip_q, bip_d;
  logic             due, good;

  assign due_lim   = CNT_W'(gap_m1_i) + CNT_W'(1);
  assign due       = synced_q && (cnt_q == due_lim);
  assign good      = is_mk_i && (hit_idx_i == lane_q);
  assign restart_o = vld_i && lock_i && (is_mk_i || due);

  always_comb begin
    synced_d = synced_q;
    demux_d  = demux_q;
    lane_d   = lane_q;
    cnt_d    = cnt_q;
    run_d    = run_q;
    len_d    = len_q;
    rep_d    = rep_q;
    mf_d     = 1'b0;
    bip_d    = '0;
    if (!lock_i) begin
      synced_d = 1'b0;
      demux_d  = 1'b0;
      cnt_d    = '0;
      run_d    = '0;
      len_d    = 1'b0;
      rep_d    = 1'b0;
    end else if (vld_i) begin
      if (!synced_q) begin
        if (is_mk_i) begin
          synced_d = 1'b1;
          demux_d  = 1'b1;
          lane_d   = hit_idx_i;
          cnt_d    = '0;
          run_d    = '0;
          rep_d    = 1'b0;
        end
      end else if (due || is_mk_i) begin
        cnt_d = '0;
        if (due && good) begin
          run_d = '0;
          len_d = 1'b0;
          rep_d = 1'b0;
          bip_d = acc_i ^ mk_bip_i;
        end else begin
          if (due) mf_d  = 1'b1;
          else     len_d = 1'b1;
          if (run_q == RUN_W'(ERR_RUN - 1)) begin
            rep_d    = 1'b1;
            synced_d = 1'b0;
            demux_d  = 1'b0;
            run_d    = '0;
          end else begin
            run_d = run_q + RUN_W'(1);
          end
        end
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      synced_q <= 1'b0;
      demux_q  <= 1'b0;
      lane_q   <= '0;
      cnt_q    <= '0;
      run_q    <= '0;
      len_q    <= 1'b0;
      rep_q    <= 1'b0;
      mf_q     <= 1'b0;
      bip_q    <= '0;
    end else begin
      synced_q <= synced_d;
      demux_q  <= demux_d;
      lane_q   <= lane_d;
      cnt_q    <= cnt_d;
      run_q    <= run_d;
      len_q    <= len_d;
      rep_q    <= rep_d;
      mf_q     <= mf_d;
      bip_q    <= bip_d;
    end
  end

  assign synced_o = synced_q;
  assign demux_o  = demux_q;
  assign lane_o   = lane_q;
  assign len_o    = len_q;
  assign rep_o    = rep_q;
  assign mf_o     = mf_q;
  assign bip_o    = bip_q;

  // R2: loss of block lock clears sync and held flags on the next edge
  a_r2_lock_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_i |=> (!synced_q && !len_q && !rep_q));

  // R4: while synced the interval count never passes the due slot
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    synced_q |-> (cnt_q <= due_lim));

  // R5: a bad-slot pulse is never followed by another on the next cycle
  a_r5_mf_single: assert property (@(posedge clk) disable iff (!rst_n)
    mf_q |=> !mf_q);

  // R7: the repeat flag only rises together with loss of sync
  a_r7_rep_drops_sync: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rep_q) |-> (!synced_q && !demux_q));

  // R8: a parity report only appears while the lane stays synced
  a_r8_bip_needs_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (|bip_q) |-> synced_q);

  // R9: the logical lane number holds while sync is kept
  a_r9_lane_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (synced_q && $past(synced_q)) |-> $stable(lane_q));

endmodule

// File: rtl/lane_marker_monitor.sv
module lane_marker_monitor
  import lmm_pkg::*;
#(
  parameter int unsigned LANES = 4,
  parameter int unsigned GAP_W = 16,
  parameter int unsigned IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     blk_lock,
  input  logic                     blk_vld,
  input  logic [1:0]               blk_hdr,
  input  logic [63:0]              blk_data,
  input  logic [GAP_W-1:0]         mk_gap_m1,
  input  logic [LANES*ID_W-1:0]    mk_table,
  output logic                     lane_synced,
  output logic                     lane_demuxed,
  output logic [IDX_W-1:0]         lane_num,
  output logic                     len_err,
  output logic                     rep_err,
  output logic                     mf_err,
  output logic [7:0]               bip_err
);

  logic             rst_meta_q, rst_sync_q;
  logic             is_mk, restart;
  logic [IDX_W-1:0] hit_idx;
  logic [7:0]       acc;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  lmm_match #(.LANES(LANES), .IDX_W(IDX_W)) u_match (
    .hdr_i     (blk_hdr),
    .data_i    (blk_data),
    .table_i   (mk_table),
    .is_mk_o   (is_mk),
    .hit_idx_o (hit_idx)
  );

  lmm_bip u_bip (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .en_i      (blk_vld),
    .restart_i (restart),
    .hdr_i     (blk_hdr),
    .data_i    (blk_data),
    .acc_o     (acc)
  );

  lmm_track #(.IDX_W(IDX_W), .GAP_W(GAP_W), .ERR_RUN(4)) u_track (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .lock_i    (blk_lock),
    .vld_i     (blk_vld),
    .is_mk_i   (is_mk),
    .hit_idx_i (hit_idx),
    .mk_bip_i  (blk_data[31:24]),
    .acc_i     (acc),
    .gap_m1_i  (mk_gap_m1),
    .restart_o (restart),
    .synced_o  (lane_synced),
    .demux_o   (lane_demuxed),
    .lane_o    (lane_num),
    .len_o     (len_err),
    .rep_o     (rep_err),
    .mf_o      (mf_err),
    .bip_o     (bip_err)
  );

  // R3: a demuxed lane is always a synced lane
  a_r3_demux_implies_sync: assert property (@(posedge clk) disable iff (!rst_sync_q)
    lane_demuxed |-> lane_synced);

endmodule

// File: tb/tb_lane_marker_monitor.sv
`timescale 1ns/1ps
module tb_lane_marker_monitor;

  localparam int GAP = 7;

  logic        clk, rst_n, blk_lock, blk_vld;
  logic [1:0]  blk_hdr;
  logic [63:0] blk_data;
  logic [15:0] mk_gap_m1;
  logic [95:0] mk_table;
  logic        lane_synced, lane_demuxed, len_err, rep_err, mf_err;
  logic [1:0]  lane_num;
  logic [7:0]  bip_err;

  int n_chk, n_err;
  logic [7:0]  acc;
  logic [63:0] seed;
  logic [23:0] ids [4];

  lane_marker_monitor dut (
    .clk(clk), .rst_n(rst_n), .blk_lock(blk_lock), .blk_vld(blk_vld),
    .blk_hdr(blk_hdr), .blk_data(blk_data), .mk_gap_m1(mk_gap_m1),
    .mk_table(mk_table), .lane_synced(lane_synced), .lane_demuxed(lane_demuxed),
    .lane_num(lane_num), .len_err(len_err), .rep_err(rep_err),
    .mf_err(mf_err), .bip_err(bip_err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [7:0] par(input logic [1:0] h, input logic [63:0] d);
    logic [7:0] p;
    p = '0;
    for (int k = 0; k < 8; k++) p = p ^ d[8*k +: 8];
    p[3] = p[3] ^ h[0];
    p[4] = p[4] ^ h[1];
    return p;
  endfunction

  function automatic logic [63:0] mk(input logic [23:0] id, input logic [7:0] b);
    return {~b, ~id[23:16], ~id[15:8], ~id[7:0], b, id[23:16], id[15:8], id[7:0]};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // One valid block, consumed by exactly one rising edge.
  task automatic blk(input logic [1:0] h, input logic [63:0] d, input bit rst_acc);
    @(negedge clk);
    blk_vld = 1'b1; blk_hdr = h; blk_data = d;
    @(posedge clk); #1;
    blk_vld = 1'b0;
    acc = rst_acc ? par(h, d) : (acc ^ par(h, d));
  endtask

  function automatic logic [63:0] next_data();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 7);
    seed = seed ^ (seed << 17);
    return seed;
  endfunction

  task automatic data_run(input int n, input int idle_between);
    for (int i = 0; i < n; i++) begin
      blk(2'b01, next_data(), 1'b0);
      chk("R5 no pulse mid-interval", mf_err, 0);
      chk("R8 no parity pulse mid-interval", bip_err, 0);
      for (int j = 0; j < idle_between; j++) begin
        @(negedge clk); blk_data = next_data();
      end
    end
  endtask

  task automatic good_marker(input int lane);
    blk(2'b10, mk(ids[lane], acc), 1'b1);
    chk("R4 on-time marker no mf_err", mf_err, 0);
    chk("R8 matching parity", bip_err, 0);
    chk("R6 len_err cleared", len_err, 0);
  endtask

  task automatic t_reset;
    chk("R1 synced in reset", lane_synced, 0);
    chk("R1 demuxed in reset", lane_demuxed, 0);
    chk("R1 flags in reset", {len_err, rep_err, mf_err, bip_err}, 0);
  endtask

  task automatic t_unknown_id;
    blk(2'b10, mk(24'h123456, 8'h00), 1'b1);
    chk("R3 unknown id stays unsynced", lane_synced, 0);
  endtask

  task automatic t_acquire;
    blk(2'b10, mk(ids[2], 8'h5A), 1'b1);
    chk("R3 synced after marker", lane_synced, 1);
    chk("R3 demuxed after marker", lane_demuxed, 1);
    chk("R3 lane number", lane_num, 2);
  endtask

  task automatic t_good_interval;
    data_run(GAP + 1, 0);
    good_marker(2);
    chk("R4 still synced", lane_synced, 1);
  endtask

  task automatic t_gappy;
    data_run(GAP + 1, 2);
    good_marker(2);
  endtask

  task automatic t_bip;
    data_run(GAP + 1, 0);
    blk(2'b10, mk(ids[2], acc ^ 8'h20), 1'b1);
    chk("R8 parity mismatch bits", bip_err, 8'h20);
    chk("R8 no mf_err on parity fault", mf_err, 0);
    data_run(GAP + 1, 0);
    good_marker(2);
  endtask

  task automatic t_missing;
    data_run(GAP + 1, 0);
    blk(2'b01, next_data(), 1'b1);
    chk("R5 missing marker pulse", mf_err, 1);
    chk("R5 sync kept after one miss", lane_synced, 1);
    data_run(GAP + 1, 0);
    good_marker(2);
  endtask

  task automatic t_wrong_lane;
    data_run(GAP + 1, 0);
    blk(2'b10, mk(ids[1], acc), 1'b1);
    chk("R5 wrong id at slot", mf_err, 1);
    chk("R9 lane number held", lane_num, 2);
    data_run(GAP + 1, 0);
    good_marker(2);
  endtask

  task automatic t_malformed;
    logic [63:0] m;
    data_run(GAP + 1, 0);
    m = mk(ids[2], acc);
    m[39:32] = m[39:32] ^ 8'h01;
    blk(2'b10, m, 1'b1);
    chk("R5 malformed marker", mf_err, 1);
    data_run(GAP + 1, 0);
    good_marker(2);
  endtask

  task automatic t_early;
    data_run(3, 0);
    blk(2'b10, mk(ids[2], acc), 1'b1);
    chk("R6 early marker sets len_err", len_err, 1);
    chk("R6 early marker no mf_err", mf_err, 0);
    data_run(GAP + 1, 0);
    chk("R6 len_err held", len_err, 1);
    good_marker(2);
  endtask

  task automatic t_repeat;
    for (int e = 1; e <= 4; e++) begin
      data_run(GAP + 1, 0);
      blk(2'b01, next_data(), 1'b1);
      chk("R5 miss pulse in run", mf_err, 1);
      chk("R7 rep_err level", rep_err, (e == 4));
      chk("R7 sync level", lane_synced, (e != 4));
    end
    chk("R7 demux dropped", lane_demuxed, 0);
    blk(2'b10, mk(ids[3], 8'h00), 1'b1);
    chk("R7 relock", lane_synced, 1);
    chk("R7 new lane", lane_num, 3);
    chk("R7 rep_err cleared", rep_err, 0);
  endtask

  task automatic t_lock_loss;
    data_run(2, 0);
    blk(2'b10, mk(ids[3], acc), 1'b1);
    chk("R6 len_err before lock loss", len_err, 1);
    @(negedge clk); blk_lock = 1'b0;
    @(posedge clk); #1;
    chk("R2 sync dropped", lane_synced, 0);
    chk("R2 demux dropped", lane_demuxed, 0);
    chk("R2 len_err cleared", len_err, 0);
    blk_lock = 1'b1;
    blk(2'b10, mk(ids[0], 8'h00), 1'b1);
    chk("R2 relock lane", lane_num, 0);
    chk("R2 relock sync", lane_synced, 1);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    n_chk = 0; n_err = 0; acc = '0; seed = 64'h0123_4567_89AB_CDEF;
    ids[0] = 24'hC16821; ids[1] = 24'h9D718E;
    ids[2] = 24'h594BE8; ids[3] = 24'h4D957B;
    mk_table  = {ids[3], ids[2], ids[1], ids[0]};
    mk_gap_m1 = 16'(GAP);
    rst_n = 1'b0; blk_lock = 1'b0; blk_vld = 1'b0;
    blk_hdr = 2'b01; blk_data = '0;
    repeat (3) @(posedge clk); #1;
    t_reset();
    @(negedge clk); rst_n = 1'b1; blk_lock = 1'b1;
    repeat (3) @(posedge clk); #1;
    t_reset();
    t_unknown_id();
    t_acquire();
    t_good_interval();
    t_gappy();
    t_bip();
    t_missing();
    t_wrong_lane();
    t_malformed();
    t_early();
    t_repeat();
    t_lock_loss();
    summary();
    $finish;
  end

endmodule